// File: doc/BRIEF.md
# Self-Timed Memory Write Control Register

This block is a one-byte control and status register that sits in front of a self-timed erase/write engine for program or data memory. Software reads and writes the byte over a simple register bus. Through it, software enables writes, picks between a row erase and a plain write, and launches the operation. It then watches a busy bit that hardware clears when the engine finishes. An error flag records operations that did not complete. This covers a warm reset that cut a cycle short and a launch attempted while writes were disabled.

Toward the engine, the block drives a one-cycle start pulse and an erase-select level. The engine's busy time is modelled inside the block by a down-counter that runs for `BUSY_CYCLES` clocks and then returns a done pulse. A one-cycle completion pulse leaves the block and can serve as an interrupt request. The memory array, address pointer, data latches and unlock sequencing lie outside this block.

Top module: `memwr_ctl_reg`

## Requirements
- R1: After a power-on reset (`rst_por` high at a clock edge), `reg_rdata` reads 0x00, `busy` is 0, and `eng_start` and `op_done_irq` are 0.
- R2: Bits 7, 6, 5 and 0 of `reg_rdata` always read 0. The layout is: bit 4 is erase select, bit 3 is the error flag, bit 2 is the write enable, and bit 1 is the start/busy bit.
- R3: A register write with bit 1 set, while the stored write enable is 1 and no cycle runs, sets the start bit at that clock edge. `eng_start` is high for exactly the following cycle.
- R4: Once launched, the start bit stays 1 for exactly `BUSY_CYCLES` cycles and is then cleared by hardware. `op_done_irq` is high for exactly the one cycle after it clears.
- R5: Software cannot clear the start bit: writing 0 to bit 1 during a cycle has no effect.
- R6: The erase select bit drives `eng_erase`. It is cleared by hardware when a cycle that ran with it set completes.
- R7: A start request made while the stored write enable is 0 launches nothing. The start bit stays 0 and the error flag is set.
- R8: A warm reset while the start bit is 1 aborts the cycle. It sets the error flag, clears the start, erase select and write enable bits, and produces no `op_done_irq`.
- R9: A warm reset while idle clears erase select and write enable but leaves the error flag unchanged.
- R10: Writing 0 to bit 3 clears the error flag. Writing 1 to bit 3 never sets it.
- R11: While the start bit is 1, writes to the erase select and write enable bits are ignored.
- R12: `busy` always equals the start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Synchronous power-on reset, active high; clears everything including the error flag |
| rst_warm | input | 1 | Synchronous warm reset, active high; aborts a running cycle, keeps the error flag |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register value |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_erase | output | 1 | Erase select level to the engine |
| busy | output | 1 | Cycle in progress |
| op_done_irq | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check four relations. The start bit rises only together with a launch pulse. A disabled launch leaves the flag set and nothing running. A running cycle holds its start bit, erase select and write enable until done or warm reset. A warm reset mid-cycle leaves the error flag set and suppresses the completion pulse. Three properties are left to the bench scenarios: the exact busy duration, the self-clearing erase select, and the error flag surviving an idle warm reset. Collisions between a register write and the completion edge need the bench's random mix as well, as does an error clear combined with an improper launch in the same write.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

    localparam int REG_W     = 8;
    localparam int POS_ERASE = 4;
    localparam int POS_ERR   = 3;
    localparam int POS_WEN   = 2;
    localparam int POS_START = 1;

    typedef struct packed {
        logic erase;
        logic err;
        logic wen;
        logic start;
    } ctrl_t;

    localparam ctrl_t CTRL_CLEAR = '{erase: 1'b0, err: 1'b0, wen: 1'b0, start: 1'b0};

    typedef struct packed {
        logic erase;
        logic err_clr;
        logic wen;
        logic go;
    } wr_req_t;

    function automatic logic [REG_W-1:0] pack_reg(input ctrl_t c);
        logic [REG_W-1:0] v;
        v            = '0;
        v[POS_ERASE] = c.erase;
        v[POS_ERR]   = c.err;
        v[POS_WEN]   = c.wen;
        v[POS_START] = c.start;
        return v;
    endfunction

    function automatic wr_req_t unpack_write(input logic [REG_W-1:0] d);
        wr_req_t r;
        r.erase   = d[POS_ERASE];
        r.err_clr = ~d[POS_ERR];
        r.wen     = d[POS_WEN];
        r.go      = d[POS_START];
        return r;
    endfunction

endpackage

// File: rtl/mwc_busy_timer.sv
module mwc_busy_timer #(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_por,
    input  logic abort,
    input  logic load,
    output logic done
);
    localparam int CW = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(BUSY_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          act_q;

    assign done = act_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst_por || abort) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            act_q <= 1'b1;
            cnt_q <= LOAD_VAL;
        end else if (done) begin
            act_q <= 1'b0;
        end else if (act_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R4: the counter never runs above its load value
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst_por)
        act_q |-> (cnt_q <= LOAD_VAL));

    // R4: done ends the countdown
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst_por)
        (done && !load) |=> !done);

endmodule

// File: rtl/mwc_ctrl_core.sv
module mwc_ctrl_core
    import mwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_por,
    input  logic             rst_warm,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             eng_done,
    output ctrl_t            ctrl,
    output logic             launch,
    output logic             start_pulse,
    output logic             done_pulse
);
    ctrl_t   ctrl_q;
    ctrl_t   ctrl_d;
    wr_req_t req;
    logic    bad_go;

    assign req    = unpack_write(reg_wdata);
    assign launch = reg_we && req.go && !ctrl_q.start && ctrl_q.wen && !rst_warm;
    assign bad_go = reg_we && req.go && !ctrl_q.start && !ctrl_q.wen;
    assign ctrl   = ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (rst_warm) begin
            ctrl_d.erase = 1'b0;
            ctrl_d.wen   = 1'b0;
            ctrl_d.start = 1'b0;
            if (ctrl_q.start) begin
                ctrl_d.err = 1'b1;
            end
        end else begin
            if (eng_done && ctrl_q.start) begin
                ctrl_d.start = 1'b0;
                ctrl_d.erase = 1'b0;
            end
            if (reg_we) begin
                if (req.err_clr) begin
                    ctrl_d.err = 1'b0;
                end
                if (!ctrl_q.start) begin
                    ctrl_d.erase = req.erase;
                    ctrl_d.wen   = req.wen;
                    if (launch) begin
                        ctrl_d.start = 1'b1;
                    end
                end
                if (bad_go) begin
                    ctrl_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_por) begin
            ctrl_q      <= CTRL_CLEAR;
            start_pulse <= 1'b0;
            done_pulse  <= 1'b0;
        end else begin
            ctrl_q      <= ctrl_d;
            start_pulse <= launch;
            done_pulse  <= !rst_warm && eng_done && ctrl_q.start;
        end
    end

    // R3: start bit rises only together with a launch pulse
    a_r3_rise_with_pulse: assert property (@(posedge clk) disable iff (rst_por)
        $rose(ctrl_q.start) |-> start_pulse);

    // R7: launch attempt with writes disabled stays idle and flags error
    a_r7_disabled_go: assert property (@(posedge clk) disable iff (rst_por)
        (reg_we && reg_wdata[POS_START] && !ctrl_q.wen && !ctrl_q.start && !rst_warm)
        |=> (!ctrl_q.start && ctrl_q.err));

    // R5: a running cycle keeps its start bit until done or warm reset
    a_r5_start_held: assert property (@(posedge clk) disable iff (rst_por)
        (ctrl_q.start && !eng_done && !rst_warm) |=> ctrl_q.start);

    // R11: enable and erase select are frozen while running
    a_r11_frozen_fields: assert property (@(posedge clk) disable iff (rst_por)
        (ctrl_q.start && !eng_done && !rst_warm) |=> ($stable(ctrl_q.wen) && $stable(ctrl_q.erase)));

    // R8: warm reset mid-cycle leaves the flag set and no completion pulse
    a_r8_warm_abort: assert property (@(posedge clk) disable iff (rst_por)
        (rst_warm && ctrl_q.start) |=> (ctrl_q.err && !ctrl_q.start && !done_pulse));

    // R4: completion pulse follows the fall of the start bit
    a_r4_pulse_on_fall: assert property (@(posedge clk) disable iff (rst_por)
        done_pulse |-> (!ctrl_q.start && $past(ctrl_q.start)));

endmodule

// File: rtl/memwr_ctl_reg.sv
module memwr_ctl_reg
    import mwc_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_por,
    input  logic       rst_warm,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       eng_start,
    output logic       eng_erase,
    output logic       busy,
    output logic       op_done_irq
);
    ctrl_t ctrl;
    logic  launch;
    logic  eng_done;

    mwc_ctrl_core u_core (
        .clk         (clk),
        .rst_por     (rst_por),
        .rst_warm    (rst_warm),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .eng_done    (eng_done),
        .ctrl        (ctrl),
        .launch      (launch),
        .start_pulse (eng_start),
        .done_pulse  (op_done_irq)
    );

    mwc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk     (clk),
        .rst_por (rst_por),
        .abort   (rst_warm),
        .load    (launch),
        .done    (eng_done)
    );

    assign reg_rdata = pack_reg(ctrl);
    assign eng_erase = ctrl.erase;
    assign busy      = ctrl.start;

    // R4: the engine finishes only while a cycle is marked running
    a_r4_done_while_busy: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
        eng_done |-> busy);

endmodule

// File: tb/memwr_ctl_reg_tb_top.sv
module memwr_ctl_reg_tb_top;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_por, rst_warm, reg_we;
    logic [7:0] reg_wdata, reg_rdata;
    logic       eng_start, eng_erase, busy, op_done_irq;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // bench reference state
    logic m_erase, m_err, m_wen, m_start, m_act, m_estart, m_irq;
    int   m_cnt;

    always #10 clk = ~clk;

    memwr_ctl_reg #(.BUSY_CYCLES(N)) dut_i (
        .clk(clk), .rst_por(rst_por), .rst_warm(rst_warm), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_erase(eng_erase), .busy(busy), .op_done_irq(op_done_irq)
    );

    function automatic logic [7:0] exp_reg();
        return {3'b000, m_erase, m_err, m_wen, m_start, 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(reg_rdata[7:5] == 3'b0 && reg_rdata[0] == 1'b0, "R2 unimplemented bits", reg_rdata, 0);
        check(reg_rdata[1] == m_start, "R3 start bit", reg_rdata[1], m_start);
        check(busy == m_start, "R12 busy", busy, m_start);
        check(eng_start == m_estart, "R3 eng_start", eng_start, m_estart);
        check(op_done_irq == m_irq, "R4 op_done_irq", op_done_irq, m_irq);
        check(reg_rdata[4] == m_erase && eng_erase == m_erase, "R6 erase select", reg_rdata[4], m_erase);
        check(reg_rdata[3] == m_err, "R10 error flag", reg_rdata[3], m_err);
        check(reg_rdata[2] == m_wen, "R11 write enable", reg_rdata[2], m_wen);
    endtask

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic cyc(input logic por, input logic warm, input logic we, input logic [7:0] wd);
        logic done;
        rst_por = por; rst_warm = warm; reg_we = we; reg_wdata = wd;
        done = m_act && (m_cnt == 0);
        m_estart = 1'b0;
        m_irq    = 1'b0;
        if (por) begin
            {m_erase, m_err, m_wen, m_start, m_act} = '0;
            m_cnt = 0;
        end else if (warm) begin
            if (m_start) m_err = 1'b1;
            {m_erase, m_wen, m_start, m_act} = '0;
        end else begin
            logic was_busy;
            was_busy = m_start;
            if (done) begin
                m_start = 1'b0; m_erase = 1'b0; m_act = 1'b0; m_irq = 1'b1;
            end else if (m_act) begin
                m_cnt--;
            end
            if (we) begin
                if (!wd[3]) m_err = 1'b0;
                if (!was_busy) begin
                    logic old_wen;
                    old_wen = m_wen;
                    m_erase = wd[4];
                    m_wen   = wd[2];
                    if (wd[1]) begin
                        if (old_wen) begin
                            m_start = 1'b1; m_act = 1'b1; m_cnt = N - 1; m_estart = 1'b1;
                        end else begin
                            m_err = 1'b1;
                        end
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int busy_len;
        void'($urandom(32'h5eed_1234));
        rst_por = 1'b1; rst_warm = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00;
        m_erase = 0; m_err = 0; m_wen = 0; m_start = 0; m_act = 0; m_estart = 0; m_irq = 0; m_cnt = 0;
        @(negedge clk);
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        // R1: reset state
        check(reg_rdata == 8'h00 && !busy && !eng_start && !op_done_irq, "R1 reset state", reg_rdata, 0);

        // R7: go with enable off
        cyc(1'b0, 1'b0, 1'b1, 8'h02);
        check(!busy && reg_rdata[3], "R7 disabled launch", reg_rdata, 8'h08);
        // R10: writing 1 to err keeps it, writing 0 clears
        cyc(1'b0, 1'b0, 1'b1, 8'h08);
        check(reg_rdata[3] == 1'b1, "R10 write one keeps flag", reg_rdata[3], 1);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check(reg_rdata[3] == 1'b0, "R10 write zero clears", reg_rdata[3], 0);
        cyc(1'b0, 1'b0, 1'b1, 8'h08);
        check(reg_rdata[3] == 1'b0, "R10 write one never sets", reg_rdata[3], 0);

        // R3/R4: write cycle, measure busy length
        cyc(1'b0, 1'b0, 1'b1, 8'h04);
        cyc(1'b0, 1'b0, 1'b1, 8'h06);
        check(eng_start && busy, "R3 launch", {eng_start, busy}, 3);
        busy_len = 1;
        // R5/R11: clear attempt of start and change of enable/erase while busy
        cyc(1'b0, 1'b0, 1'b1, 8'h10);
        busy_len++;
        check(busy && reg_rdata[2] && !reg_rdata[4], "R5 R11 ignored while busy", reg_rdata, 8'h06);
        while (busy && busy_len < N + 4) begin
            cyc(1'b0, 1'b0, 1'b0, 8'h00);
            if (busy) busy_len++;
        end
        check(busy_len == N, "R4 busy length", busy_len, N);
        check(op_done_irq, "R4 completion pulse", op_done_irq, 1);
        idle(1);
        check(!op_done_irq, "R4 pulse one cycle", op_done_irq, 0);

        // R6: erase cycle clears erase select at completion
        cyc(1'b0, 1'b0, 1'b1, 8'h16);
        check(eng_erase && busy, "R6 erase launch", {eng_erase, busy}, 3);
        idle(N);
        check(!eng_erase && !busy && reg_rdata[2], "R6 erase self-clear", reg_rdata, 8'h04);

        // R8: warm reset mid-cycle
        cyc(1'b0, 1'b0, 1'b1, 8'h16);
        idle(3);
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        check(reg_rdata == 8'h08 && !busy, "R8 warm abort", reg_rdata, 8'h08);
        idle(N + 2);
        check(reg_rdata == 8'h08, "R8 no late completion", reg_rdata, 8'h08);

        // R9: warm reset while idle keeps flag
        cyc(1'b0, 1'b0, 1'b1, 8'h1C);
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        check(reg_rdata == 8'h08, "R9 idle warm reset", reg_rdata, 8'h08);

        // random mix, biased toward launches
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] wd;
            logic we, warm;
            wd   = 8'($urandom);
            if ($urandom_range(0, 3) != 0) wd[2] = 1'b1;
            we   = ($urandom_range(0, 3) == 0);
            warm = ($urandom_range(0, 60) == 0);
            cyc(1'b0, warm, we, wd);
        end
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        check(reg_rdata == 8'h00, "R1 reset after random", reg_rdata, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule